// File: doc/BRIEF.md
# Reset Exception Sequencer

This block stands between a raw active-low reset pin and the processor core. It passes the pin and a non-maskable interrupt level through a two-stage synchronizer. It then filters out reset pulses that are too short to count. A reset that qualifies is classed by the interrupt level. With the interrupt line high it is a power-on reset. With the line low it is a manual reset. The block drives three separate active-low reset outputs: one for the core, one for the general peripherals, and one for the bus-control, pin-function and port domain.

A manual reset leaves the bus-control domain running, so memory refresh continues. It also waits until any bus cycle in progress has ended. When the pin is released, the block reads two words from a vector table over a 32-bit request/acknowledge read port. The first word is the start address and the second is the stack pointer. The vector base register is cleared and the interrupt mask is set to all ones. The block then loads the program counter and the stack pointer and pulses a start strobe for one cycle. A new qualified reset that arrives while the vectors are being read aborts the reads and classifies the new reset.

Top module: `reset_seq_top`

## Requirements
- R1: `res_n_in` and `nmi_in` each pass through a two-flop synchronizer. When a reset qualifies, `rst_kind` records the class taken from the synchronized NMI level: 0 means power-on (NMI high) and 1 means manual (NMI low).
- R2: A reset qualifies only after the synchronized reset has been low for 20 consecutive cycles. A shorter low pulse has no effect: `busy` stays 0 and all reset outputs stay 1.
- R3: During a power-on reset hold, `cpu_rst_n`, `periph_rst_n` and `busctl_rst_n` are all 0.
- R4: During a manual reset hold, `cpu_rst_n` and `periph_rst_n` are 0 and `busctl_rst_n` stays 1.
- R5: A manual reset that qualifies while `bus_busy` is 1 changes none of the reset outputs until `bus_busy` is 0. During that wait `busy` is 1. A power-on reset is never deferred.
- R6: After the synchronized reset goes high, `rd_req` is raised with `rd_addr` set to base+0, which is the PC vector. After an acknowledge it moves to base+4, which is the SP vector. The base is 0x0 for power-on and 0x8 for manual. `rd_req` stays high through any number of wait cycles until `rd_ack` arrives.
- R7: When the vector reads begin, `vbr_out` becomes 0x00000000 and `imask_out` becomes 4'b1111.
- R8: On the edge that accepts the SP acknowledge, `pc_out` and `sp_out` load the two fetched words. `start_pulse` is 1 for exactly the following cycle. `cpu_rst_n` stays 0 from the hold until that cycle.
- R9: A new qualified reset during the vector reads or the start cycle abandons the reads. It is classified afresh and the whole sequence restarts from the new class's vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer itself |
| res_n_in | input | 1 | Asynchronous active-low reset pin |
| nmi_in | input | 1 | Asynchronous NMI level that selects the reset class |
| bus_busy | input | 1 | A bus cycle is in progress |
| rd_ack | input | 1 | Read acknowledge; rd_data valid |
| rd_data | input | 32 | Read data |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| cpu_rst_n | output | 1 | Core reset, active low |
| periph_rst_n | output | 1 | General peripheral reset, active low |
| busctl_rst_n | output | 1 | Bus-control, pin-function and port reset, active low |
| rst_kind | output | 1 | Class of the last qualified reset (0 power-on, 1 manual) |
| busy | output | 1 | Sequencer is not idle |
| pc_out | output | 32 | Loaded program counter |
| sp_out | output | 32 | Loaded stack pointer |
| vbr_out | output | 32 | Vector base register |
| imask_out | output | 4 | Interrupt mask |
| start_pulse | output | 1 | One-cycle execution start strobe |

## Verification
Suppose the pin goes low just before edge E1. The synchronized copy is low after E2. The hold state, and with it the reset outputs, is entered on E22. After the pin is released, the read request appears two edges after the release is sampled. The PC and SP registers load on the edge that takes the second acknowledge, and the start strobe follows one cycle later. The bench models these latencies with a behavioural model that advances on every rising edge. It compares every output on the following falling edge, so each result is checked in the exact cycle it is due. Targeted checks at the same sampling points cover the short pulse, the deferral window, the undeferred power-on reset and the abort.

// File: rtl/reset_seq_pkg.sv
// Shared types for the reset exception sequencer.
// Assumes: state encoding is internal; only rst_kind value is visible at ports.
package reset_seq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_DEFER = 3'd1,
        SQ_HOLD  = 3'd2,
        SQ_FPC   = 3'd3,
        SQ_FSP   = 3'd4,
        SQ_GO    = 3'd5
    } seq_state_t;

    typedef enum logic {
        RK_POWERON = 1'b0,
        RK_MANUAL  = 1'b1
    } rst_kind_t;
endpackage

// File: rtl/sync_chain.sv
// Multi-stage level synchronizer for a vector of asynchronous inputs.
// Assumes: STAGES >= 2; RST_VAL is the level reported while the block is in reset.
module sync_chain #(
    parameter int          STAGES  = 2,
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // One flop stage of the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[i] <= RST_VAL;
            else if (i == 0) stage[i] <= d;
            else stage[i] <= stage[(i == 0) ? 0 : i - 1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/rst_qualify.sv
// Reset pulse qualifier: synchronizes reset and NMI and counts low cycles.
// Emits a one-cycle qual strobe on the MIN_LOW-th consecutive low cycle.
// Assumes: counter saturates at MIN_LOW and clears whenever reset is high.
module rst_qualify #(
    parameter int STAGES  = 2,
    parameter int MIN_LOW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic res_n_raw,
    input  logic nmi_raw,
    output logic res_s,
    output logic nmi_s,
    output logic qual
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [1:0]    synced;
    logic [CW-1:0] low_cnt;

    sync_chain #(.STAGES(STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nmi_raw, res_n_raw}),
        .q     (synced)
    );

    assign res_s = synced[0];
    assign nmi_s = synced[1];

    // Saturating count of consecutive synchronized low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || res_s) low_cnt <= '0;
        else if (low_cnt != CW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
    end

    assign qual = !res_s && (low_cnt == CW'(MIN_LOW - 1));
endmodule

// File: rtl/rst_seq_fsm.sv
// Sequencer FSM: classifies, defers manual resets, holds, fetches vectors, starts.
// Assumes: qual is a single-cycle strobe; rd_ack is only meaningful in fetch states.
module rst_seq_fsm
    import reset_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qual,
    input  logic       res_s,
    input  logic       nmi_s,
    input  logic       bus_busy,
    input  logic       rd_ack,
    output seq_state_t state,
    output rst_kind_t  kind,
    output logic       init_ctl,
    output logic       ld_pc,
    output logic       ld_fin
);
    seq_state_t nxt;
    logic       can_restart;

    assign can_restart = (state == SQ_IDLE) || (state == SQ_FPC) ||
                         (state == SQ_FSP)  || (state == SQ_GO);

    // Next-state selection; a qualified reset overrides the normal flow.
    always_comb begin
        nxt = state;
        case (state)
            SQ_IDLE:  nxt = SQ_IDLE;
            SQ_DEFER: if (!bus_busy) nxt = SQ_HOLD;
            SQ_HOLD:  if (res_s)     nxt = SQ_FPC;
            SQ_FPC:   if (rd_ack)    nxt = SQ_FSP;
            SQ_FSP:   if (rd_ack)    nxt = SQ_GO;
            SQ_GO:    nxt = SQ_IDLE;
            default:  nxt = SQ_IDLE;
        endcase
        if (qual && can_restart)
            nxt = (!nmi_s && bus_busy) ? SQ_DEFER : SQ_HOLD;
    end

    // State and reset-class registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            kind  <= RK_POWERON;
        end else begin
            state <= nxt;
            if (qual && can_restart) kind <= nmi_s ? RK_POWERON : RK_MANUAL;
        end
    end

    assign init_ctl = (state == SQ_HOLD) && (nxt == SQ_FPC);
    assign ld_pc    = (state == SQ_FPC)  && (nxt == SQ_FSP);
    assign ld_fin   = (state == SQ_FSP)  && (nxt == SQ_GO);
endmodule

// File: rtl/vec_regs.sv
// Architectural registers written by the reset sequence: PC, SP, VBR, mask.
// Assumes: ld_pc precedes ld_fin within one sequence.
module vec_regs #(
    parameter int DW = 32,
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_ctl,
    input  logic          ld_pc,
    input  logic          ld_fin,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] vbr_out,
    output logic [MW-1:0] imask_out
);
    logic [DW-1:0] pc_tmp;

    // Captures the fetched words and applies the control-register init.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_tmp    <= '0;
            pc_out    <= '0;
            sp_out    <= '0;
            vbr_out   <= '0;
            imask_out <= '1;
        end else begin
            if (init_ctl) begin
                vbr_out   <= '0;
                imask_out <= '1;
            end
            if (ld_pc) pc_tmp <= rd_data;
            if (ld_fin) begin
                pc_out <= pc_tmp;
                sp_out <= rd_data;
            end
        end
    end
endmodule

// File: rtl/reset_seq_top.sv
// Top of the reset exception sequencer: qualifier, FSM, registers, output decode.
// Assumes: raw pins are asynchronous; rd_* follows a req/ack handshake.
module reset_seq_top
    import reset_seq_pkg::*;
#(
    parameter int          STAGES   = 2,
    parameter int          MIN_LOW  = 20,
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter int          MW       = 4,
    parameter logic [AW-1:0] PON_BASE = 32'h0,
    parameter logic [AW-1:0] MAN_BASE = 32'h8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_n_in,
    input  logic          nmi_in,
    input  logic          bus_busy,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          cpu_rst_n,
    output logic          periph_rst_n,
    output logic          busctl_rst_n,
    output logic          rst_kind,
    output logic          busy,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] vbr_out,
    output logic [MW-1:0] imask_out,
    output logic          start_pulse
);
    localparam logic [AW-1:0] SP_OFS = AW'(DW / 8);

    logic       res_s, nmi_s, qual;
    logic       init_ctl, ld_pc, ld_fin;
    seq_state_t state;
    rst_kind_t  kind;

    rst_qualify #(.STAGES(STAGES), .MIN_LOW(MIN_LOW)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_n_raw (res_n_in),
        .nmi_raw   (nmi_in),
        .res_s     (res_s),
        .nmi_s     (nmi_s),
        .qual      (qual)
    );

    rst_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual     (qual),
        .res_s    (res_s),
        .nmi_s    (nmi_s),
        .bus_busy (bus_busy),
        .rd_ack   (rd_ack),
        .state    (state),
        .kind     (kind),
        .init_ctl (init_ctl),
        .ld_pc    (ld_pc),
        .ld_fin   (ld_fin)
    );

    vec_regs #(.DW(DW), .MW(MW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_ctl  (init_ctl),
        .ld_pc     (ld_pc),
        .ld_fin    (ld_fin),
        .rd_data   (rd_data),
        .pc_out    (pc_out),
        .sp_out    (sp_out),
        .vbr_out   (vbr_out),
        .imask_out (imask_out)
    );

    // Output decode of reset domains, read port and status from state.
    always_comb begin
        cpu_rst_n    = !((state == SQ_HOLD) || (state == SQ_FPC) || (state == SQ_FSP));
        periph_rst_n = (state != SQ_HOLD);
        busctl_rst_n = !((state == SQ_HOLD) && (kind == RK_POWERON));
        rd_req       = (state == SQ_FPC) || (state == SQ_FSP);
        rd_addr      = '0;
        if (rd_req)
            rd_addr = ((kind == RK_MANUAL) ? MAN_BASE : PON_BASE) +
                      ((state == SQ_FSP) ? SP_OFS : '0);
        busy         = (state != SQ_IDLE);
        start_pulse  = (state == SQ_GO);
        rst_kind     = (kind == RK_MANUAL);
    end
endmodule

// File: rtl/reset_seq_checks.sv
// Property checker for reset_seq_top, attached by bind below.
// Assumes: connected to top-level ports plus the qualifier outputs res_s and qual.
module reset_seq_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        res_s,
    input logic        qual,
    input logic        bus_busy,
    input logic        rd_req,
    input logic        rd_ack,
    input logic [31:0] rd_addr,
    input logic        cpu_rst_n,
    input logic        periph_rst_n,
    input logic        busctl_rst_n,
    input logic        rst_kind,
    input logic        busy,
    input logic [31:0] vbr_out,
    input logic [3:0]  imask_out,
    input logic        start_pulse
);
    a_r2_qual_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> $past(!res_s));

    a_r3_poweron_all_domains: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_rst_n && !rst_kind) |-> (!busctl_rst_n && !cpu_rst_n));

    a_r4_manual_keeps_busctl: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_rst_n && rst_kind) |-> (busctl_rst_n && !cpu_rst_n));

    a_r5_manual_waits_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(periph_rst_n) && rst_kind) |-> !$past(bus_busy));

    a_r6_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (busy && !cpu_rst_n));

    a_r7_ctl_init_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (vbr_out == 32'h0 && imask_out == 4'hF));

    a_r8_start_after_sp_ack: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(rd_req && rd_ack && rd_addr[2]));

    a_r8_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
endmodule

bind reset_seq_top reset_seq_checks u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_s        (res_s),
    .qual         (qual),
    .bus_busy     (bus_busy),
    .rd_req       (rd_req),
    .rd_ack       (rd_ack),
    .rd_addr      (rd_addr),
    .cpu_rst_n    (cpu_rst_n),
    .periph_rst_n (periph_rst_n),
    .busctl_rst_n (busctl_rst_n),
    .rst_kind     (rst_kind),
    .busy         (busy),
    .vbr_out      (vbr_out),
    .imask_out    (imask_out),
    .start_pulse  (start_pulse)
);

// File: tb/reset_seq_top_test.sv
// Bench: behavioural cycle model compared on every falling edge, plus targeted checks.
module reset_seq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 0, rst_n = 0, res_n_in = 1, nmi_in = 1, bus_busy = 0;
    logic        rd_ack = 0;
    logic [31:0] rd_data = 0;
    logic        rd_req, cpu_rst_n, periph_rst_n, busctl_rst_n, rst_kind, busy, start_pulse;
    logic [31:0] rd_addr, pc_out, sp_out, vbr_out;
    logic [3:0]  imask_out;

    int errors = 0, checks = 0, cycles = 0, wait_cfg = 0, waitc = 0, busy_cycles = 0;
    bit done = 0;

    reset_seq_top uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] memv(logic [31:0] a);
        return 32'hC0DE_1357 ^ {a[15:0], ~a[15:0]};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Reference model state (behavioural, per requirement text).
    int m_st = 0, m_cnt = 0;
    bit m_s1 = 1, m_s2 = 1, m_n1 = 1, m_n2 = 1, m_kind = 0;
    logic [31:0] m_pctmp = 0, m_pc = 0, m_sp = 0, m_vbr = 0;
    logic [3:0]  m_mask = 4'hF;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_s1 = 1; m_s2 = 1; m_n1 = 1; m_n2 = 1; m_kind = 0;
            m_pctmp = 0; m_pc = 0; m_sp = 0; m_vbr = 0; m_mask = 4'hF;
        end else begin
            automatic bit q = !m_s2 && (m_cnt == 19);
            automatic int ns = m_st;
            case (m_st)
                1: if (!bus_busy) ns = 2;
                2: if (m_s2) ns = 3;
                3: if (rd_ack) ns = 4;
                4: if (rd_ack) ns = 5;
                5: ns = 0;
                default: ns = m_st;
            endcase
            if (q && (m_st == 0 || m_st >= 3)) begin
                ns = (!m_n2 && bus_busy) ? 1 : 2;
                m_kind = !m_n2;
            end
            if (m_st == 2 && ns == 3) begin m_vbr = 0; m_mask = 4'hF; end
            if (m_st == 3 && ns == 4) m_pctmp = rd_data;
            if (m_st == 4 && ns == 5) begin m_pc = m_pctmp; m_sp = rd_data; end
            if (m_s2) m_cnt = 0; else if (m_cnt < 20) m_cnt++;
            m_s2 = m_s1; m_s1 = res_n_in; m_n2 = m_n1; m_n1 = nmi_in;
            m_st = ns;
        end
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (busy) busy_cycles++;
        if (rst_n && !done) begin
            chk("R1", "rst_kind", 32'(rst_kind), 32'(m_kind));
            chk("R2", "busy", 32'(busy), 32'(m_st != 0));
            chk("R3", "cpu_rst_n", 32'(cpu_rst_n), 32'(!(m_st >= 2 && m_st <= 4)));
            chk("R4", "periph_rst_n", 32'(periph_rst_n), 32'(m_st != 2));
            chk("R4", "busctl_rst_n", 32'(busctl_rst_n), 32'(!(m_st == 2 && !m_kind)));
            chk("R6", "rd_req", 32'(rd_req), 32'(m_st == 3 || m_st == 4));
            if (m_st == 3 || m_st == 4)
                chk("R6", "rd_addr", rd_addr, (m_kind ? 32'h8 : 32'h0) + (m_st == 4 ? 32'h4 : 32'h0));
            chk("R7", "vbr_out", vbr_out, m_vbr);
            chk("R7", "imask_out", 32'(imask_out), 32'(m_mask));
            chk("R8", "pc_out", pc_out, m_pc);
            chk("R8", "sp_out", sp_out, m_sp);
            chk("R8", "start_pulse", 32'(start_pulse), 32'(m_st == 5));
        end
        // Memory responder with wait_cfg wait cycles before each acknowledge.
        if (!rd_req || rd_ack) begin
            rd_ack = 0; waitc = wait_cfg;
        end else if (waitc == 0) begin
            rd_ack = 1; rd_data = memv(rd_addr);
        end else waitc--;
        if (cycles > WATCHDOG && !done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic res_low(int n);
        @(negedge clk); res_n_in = 0;
        repeat (n) @(negedge clk);
        res_n_in = 1;
    endtask

    task automatic seq_done(logic [31:0] base);
        repeat (60) @(negedge clk);
        chk("R8", "final pc", pc_out, memv(base));
        chk("R8", "final sp", sp_out, memv(base + 4));
        chk("R7", "final vbr", vbr_out, 32'h0);
        chk("R7", "final imask", 32'(imask_out), 32'hF);
        chk("R2", "idle after sequence", 32'(busy), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset kind", 32'(rst_kind), 32'h0);
        chk("R3", "reset outputs idle", {29'h0, cpu_rst_n, periph_rst_n, busctl_rst_n}, 32'h7);
        chk("R8", "reset start", 32'(start_pulse), 32'h0);
        rst_n = 1;

        // Power-on reset, two wait cycles per read.
        wait_cfg = 2; nmi_in = 1;
        res_low(30);
        seq_done(32'h0);
        chk("R1", "power-on class", 32'(rst_kind), 32'h0);

        // 19-cycle pulse must be ignored (R2); then manual reset, zero waits.
        busy_cycles = 0; nmi_in = 0; wait_cfg = 0;
        res_low(19);
        repeat (8) @(negedge clk);
        chk("R2", "short pulse busy cycles", 32'(busy_cycles), 32'h0);
        chk("R2", "short pulse periph", 32'(periph_rst_n), 32'h1);
        res_low(20);
        seq_done(32'h8);
        chk("R1", "manual class", 32'(rst_kind), 32'h1);

        // Manual reset deferred by a bus cycle (R5).
        nmi_in = 0; wait_cfg = 3;
        @(negedge clk); bus_busy = 1;
        res_low(25);
        repeat (10) @(negedge clk);
        chk("R5", "deferred periph", 32'(periph_rst_n), 32'h1);
        chk("R5", "deferred cpu", 32'(cpu_rst_n), 32'h1);
        chk("R5", "deferred busy", 32'(busy), 32'h1);
        bus_busy = 0;
        @(negedge clk);
        chk("R5", "after bus end periph", 32'(periph_rst_n), 32'h0);
        chk("R4", "manual busctl kept", 32'(busctl_rst_n), 32'h1);
        seq_done(32'h8);

        // Power-on reset is not deferred by a bus cycle (R5, R3).
        nmi_in = 1; bus_busy = 1; wait_cfg = 1;
        @(negedge clk); res_n_in = 0;
        repeat (24) @(negedge clk);
        chk("R5", "power-on undeferred periph", 32'(periph_rst_n), 32'h0);
        chk("R3", "power-on busctl", 32'(busctl_rst_n), 32'h0);
        res_n_in = 1; bus_busy = 0;
        seq_done(32'h0);

        // Abort during the vector reads (R9).
        nmi_in = 1; wait_cfg = 60;
        res_low(22);
        repeat (8) @(negedge clk);
        chk("R9", "in fetch before abort", 32'(rd_req), 32'h1);
        nmi_in = 0;
        res_low(25);
        chk("R9", "abort class", 32'(rst_kind), 32'h1);
        chk("R9", "abort holds periph", 32'(periph_rst_n), 32'h0);
        wait_cfg = 1;
        repeat (3) @(negedge clk);
        chk("R9", "restart addr", rd_addr, 32'h8);
        seq_done(32'h8);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule